// File: doc/BRIEF.md
# VLAN Membership Table Sequencer

This block turns one host command (read, write or delete of a VLAN table entry) into the sequence of register accesses that an indirect table needs. It issues these accesses over a simple request/acknowledge register port. For each command it sets the table index register to the VLAN ID. For writes and deletes it loads the entry word. It then starts the table operation through the access register and keeps reading that register until the hardware reports that the operation is finished. A read then fetches the entry word and returns it to the host.

Each of the nine ports has a 16-bit default-VLAN register. A write or delete keeps these registers consistent with the table. A write sets the default of each port that it names as untagged or as default. It clears any other port that still points at the VLAN. A delete clears every port that points at the VLAN before it empties the entry. Commands that cannot be carried out end at once with an error. A write with no members ends at once without one.

Top module: `vlan_tbl_seq`

## Requirements
- R1: `cmdReady` is high exactly when the block is idle, and a command is taken only on a cycle with `cmdValid` and `cmdReady` both high. `cmdValid` has no effect while the block is busy. Every accepted command ends with `rspDone` high for exactly one cycle. During that cycle `rspErr` gives the result.
- R2: Command codes are 0 = read, 1 = write, 2 = delete. A VLAN ID of 0, or the code 3, ends the command with an error and makes no register transfer.
- R3: A write with an all-zero member mask ends without an error and makes no register transfer.
- R4: A write visits ports 0 to 8 in order. The default register of port p is at DEF_BASE + 2·p. A port in the untagged or default mask is written with the VLAN ID. Otherwise, a port set in VALID_MASK is read, and it is written with 0 if it holds the VLAN ID. Ports outside VALID_MASK are not accessed.
- R5: A delete reads the default register of every port, 0 to 8, and writes 0 to each one that holds the VLAN ID. This happens before any table register is touched.
- R6: The table operation first writes the VLAN ID, zero-extended, to the index register. For a write it then writes the entry register with the member mask in bits 8:0 and the untagged mask in bits 17:9. For a delete it writes 0 there instead. It then writes the access register with 0x80 for a write or delete, or with 0x81 for a read.
- R7: After the start, the access register is read again until bit 7 reads 0. If 100 reads in a row show bit 7 set, the command ends with an error.
- R8: After a successful read, the entry register is read and its value appears on `rspEntry`. That value is held until the next successful read.
- R9: A transfer acknowledged with `regErr` high ends the command with an error. No further transfer is made.
- R10: `regReq`, `regWrite`, `regAddr` and `regWdata` stay stable from the start of a request until the cycle in which `regAck` is high. That cycle completes the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present |
| cmdOp | input | 2 | 0 read, 1 write, 2 delete |
| cmdVid | input | 12 | VLAN ID |
| cmdMembers | input | 9 | Member port mask |
| cmdUntag | input | 9 | Untagged port mask |
| cmdDefault | input | 9 | Ports that take this VLAN as default |
| cmdReady | output | 1 | Idle, command can be taken |
| rspDone | output | 1 | One-cycle completion pulse |
| rspErr | output | 1 | Error result, valid with rspDone |
| rspEntry | output | 32 | Entry word from the last successful read |
| regReq | output | 1 | Register transfer request |
| regWrite | output | 1 | 1 write, 0 read |
| regAddr | output | 8 | Register address |
| regWdata | output | 32 | Write data |
| regAck | input | 1 | Transfer completes this cycle |
| regErr | input | 1 | Transfer failed, valid with regAck |
| regRdata | input | 32 | Read data, valid with regAck |

## Verification
Three outcomes can meet in the same acknowledged poll read: the busy bit reporting done, the poll limit being reached, and a transport error. The bench models a register slave whose busy count, acknowledge delay and error position are chosen for each command. Runs with 99 and 100 busy reads check that the 100th poll succeeds when the bit clears and fails when it does not. An error placed on a poll or on a default-register access checks that the command stops with no later transfer. A new command driven while the block is busy checks that the transfer stream still matches the one predicted for the accepted command.

// File: rtl/vlan_seq_pkg.sv
package vlan_seq_pkg;

  localparam logic [1:0] OP_READ   = 2'd0;
  localparam logic [1:0] OP_WRITE  = 2'd1;
  localparam logic [1:0] OP_DELETE = 2'd2;

  typedef enum logic [3:0] {
    BUS_NONE,
    BUS_DEF_SET,
    BUS_DEF_RD,
    BUS_DEF_CLR,
    BUS_IDX,
    BUS_ENTRY_WR,
    BUS_ACC_WR,
    BUS_ACC_RD,
    BUS_ENTRY_RD
  } busSel_t;

  typedef struct packed {
    logic    loadCmd;
    logic    portRst;
    logic    portInc;
    logic    pollRst;
    logic    pollInc;
    logic    capEntry;
    busSel_t busSel;
  } seqStrobe_t;

  typedef struct packed {
    logic opRead;
    logic opWrite;
    logic opDelete;
    logic opBad;
    logic vidZero;
    logic memEmpty;
    logic portUpd;
    logic portValid;
    logic portLast;
    logic defMatch;
    logic accBusy;
    logic pollLast;
  } seqStatus_t;

endpackage

// File: rtl/vlan_seq_dp.sv
module vlan_seq_dp
  import vlan_seq_pkg::*;
#(
  parameter int NUM_PORTS = 9,
  parameter int VID_W = 12,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int POLL_LIMIT = 100,
  parameter logic [NUM_PORTS-1:0] VALID_MASK = 9'h11F,
  parameter int IDX_ADDR = 8'h10,
  parameter int ENTRY_ADDR = 8'h14,
  parameter int ACC_ADDR = 8'h1C,
  parameter int DEF_BASE = 8'h40
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  seqStrobe_t           stb,
  input  logic [1:0]           cmdOp,
  input  logic [VID_W-1:0]     cmdVid,
  input  logic [NUM_PORTS-1:0] cmdMembers,
  input  logic [NUM_PORTS-1:0] cmdUntag,
  input  logic [NUM_PORTS-1:0] cmdDefault,
  input  logic [DATA_W-1:0]    regRdata,
  output seqStatus_t           status,
  output logic                 regWrite,
  output logic [ADDR_W-1:0]    regAddr,
  output logic [DATA_W-1:0]    regWdata,
  output logic [DATA_W-1:0]    rspEntry
);

  localparam int PORT_W = $clog2(NUM_PORTS);
  localparam int POLL_W = $clog2(POLL_LIMIT);
  localparam int DEF_W = 16;
  localparam int START_BIT = 7;
  localparam int ENTRY_W = 2 * NUM_PORTS;

  logic [1:0]           opR;
  logic [VID_W-1:0]     vidR;
  logic [NUM_PORTS-1:0] memR, untR, dflR;
  logic [PORT_W-1:0]    portIdx;
  logic [POLL_W-1:0]    pollCnt;
  logic [NUM_PORTS-1:0] updMask;
  logic [ENTRY_W-1:0]   entryWord;
  logic [DATA_W-1:0]    accWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opR  <= '0;
      vidR <= '0;
      memR <= '0;
      untR <= '0;
      dflR <= '0;
    end else if (stb.loadCmd) begin
      opR  <= cmdOp;
      vidR <= cmdVid;
      memR <= cmdMembers;
      untR <= cmdUntag;
      dflR <= cmdDefault;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.portRst) portIdx <= '0;
    else if (stb.portInc)     portIdx <= portIdx + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.pollRst) pollCnt <= '0;
    else if (stb.pollInc)     pollCnt <= pollCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             rspEntry <= '0;
    else if (stb.capEntry) rspEntry <= regRdata;
  end

  assign updMask   = untR | dflR;
  assign entryWord = {untR, memR};

  always_comb begin
    accWord            = '0;
    accWord[START_BIT] = 1'b1;
    accWord[0]         = (opR == OP_READ);
  end

  always_comb begin
    status.opRead    = (opR == OP_READ);
    status.opWrite   = (opR == OP_WRITE);
    status.opDelete  = (opR == OP_DELETE);
    status.opBad     = (opR == 2'd3);
    status.vidZero   = (vidR == '0);
    status.memEmpty  = (memR == '0);
    status.portUpd   = updMask[portIdx];
    status.portValid = VALID_MASK[portIdx];
    status.portLast  = (portIdx == PORT_W'(NUM_PORTS - 1));
    status.defMatch  = (regRdata[DEF_W-1:0] == DEF_W'(vidR));
    status.accBusy   = regRdata[START_BIT];
    status.pollLast  = (pollCnt == POLL_W'(POLL_LIMIT - 1));
  end

  always_comb begin
    regWrite = 1'b0;
    regAddr  = '0;
    regWdata = '0;
    case (stb.busSel)
      BUS_DEF_SET: begin
        regWrite = 1'b1;
        regAddr  = ADDR_W'(DEF_BASE) + ADDR_W'({portIdx, 1'b0});
        regWdata = DATA_W'(vidR);
      end
      BUS_DEF_RD: begin
        regAddr  = ADDR_W'(DEF_BASE) + ADDR_W'({portIdx, 1'b0});
      end
      BUS_DEF_CLR: begin
        regWrite = 1'b1;
        regAddr  = ADDR_W'(DEF_BASE) + ADDR_W'({portIdx, 1'b0});
      end
      BUS_IDX: begin
        regWrite = 1'b1;
        regAddr  = ADDR_W'(IDX_ADDR);
        regWdata = DATA_W'(vidR);
      end
      BUS_ENTRY_WR: begin
        regWrite = 1'b1;
        regAddr  = ADDR_W'(ENTRY_ADDR);
        regWdata = (opR == OP_WRITE) ? DATA_W'(entryWord) : '0;
      end
      BUS_ACC_WR: begin
        regWrite = 1'b1;
        regAddr  = ADDR_W'(ACC_ADDR);
        regWdata = accWord;
      end
      BUS_ACC_RD:   regAddr = ADDR_W'(ACC_ADDR);
      BUS_ENTRY_RD: regAddr = ADDR_W'(ENTRY_ADDR);
      default: ;
    endcase
  end

  AST_ENTRY_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.capEntry |=> $stable(rspEntry)); // R8
  AST_PORT_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    stb.portInc |=> portIdx < PORT_W'(NUM_PORTS)); // R4

endmodule

// File: rtl/vlan_seq_ctrl.sv
module vlan_seq_ctrl
  import vlan_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic       regAck,
  input  logic       regErr,
  input  seqStatus_t status,
  output seqStrobe_t stb,
  output logic       regReq,
  output logic       cmdReady,
  output logic       rspDone,
  output logic       rspErr
);

  typedef enum logic [3:0] {
    S_IDLE, S_CHECK, S_PORT_EVAL, S_DEF_SET, S_DEF_RD, S_DEF_CLR,
    S_IDX, S_ENTRY_WR, S_ACC_WR, S_POLL, S_ENTRY_RD, S_FIN_OK, S_FIN_ERR
  } seqState_t;

  seqState_t state, nxt;
  logic xferOk, xferBad, doAdv;

  assign xferOk  = regAck && !regErr;
  assign xferBad = regAck && regErr;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    nxt   = state;
    stb   = '0;
    stb.busSel = BUS_NONE;
    doAdv = 1'b0;
    case (state)
      S_IDLE: if (cmdValid) begin
        stb.loadCmd = 1'b1;
        stb.portRst = 1'b1;
        nxt = S_CHECK;
      end
      S_CHECK: begin
        if (status.opBad || status.vidZero)        nxt = S_FIN_ERR;
        else if (status.opWrite && status.memEmpty) nxt = S_FIN_OK;
        else if (status.opRead)                     nxt = S_IDX;
        else                                        nxt = S_PORT_EVAL;
      end
      S_PORT_EVAL: begin
        if (status.opWrite && status.portUpd)          nxt = S_DEF_SET;
        else if (status.opDelete || status.portValid)  nxt = S_DEF_RD;
        else                                           doAdv = 1'b1;
      end
      S_DEF_SET, S_DEF_CLR: begin
        stb.busSel = (state == S_DEF_SET) ? BUS_DEF_SET : BUS_DEF_CLR;
        if (xferBad)     nxt = S_FIN_ERR;
        else if (xferOk) doAdv = 1'b1;
      end
      S_DEF_RD: begin
        stb.busSel = BUS_DEF_RD;
        if (xferBad) nxt = S_FIN_ERR;
        else if (xferOk) begin
          if (status.defMatch) nxt = S_DEF_CLR;
          else                 doAdv = 1'b1;
        end
      end
      S_IDX: begin
        stb.busSel = BUS_IDX;
        if (xferBad)     nxt = S_FIN_ERR;
        else if (xferOk) nxt = status.opRead ? S_ACC_WR : S_ENTRY_WR;
      end
      S_ENTRY_WR: begin
        stb.busSel = BUS_ENTRY_WR;
        if (xferBad)     nxt = S_FIN_ERR;
        else if (xferOk) nxt = S_ACC_WR;
      end
      S_ACC_WR: begin
        stb.busSel = BUS_ACC_WR;
        if (xferBad) nxt = S_FIN_ERR;
        else if (xferOk) begin
          stb.pollRst = 1'b1;
          nxt = S_POLL;
        end
      end
      S_POLL: begin
        stb.busSel = BUS_ACC_RD;
        if (xferBad) nxt = S_FIN_ERR;
        else if (xferOk) begin
          if (!status.accBusy)      nxt = status.opRead ? S_ENTRY_RD : S_FIN_OK;
          else if (status.pollLast) nxt = S_FIN_ERR;
          else                      stb.pollInc = 1'b1;
        end
      end
      S_ENTRY_RD: begin
        stb.busSel = BUS_ENTRY_RD;
        if (xferBad) nxt = S_FIN_ERR;
        else if (xferOk) begin
          stb.capEntry = 1'b1;
          nxt = S_FIN_OK;
        end
      end
      S_FIN_OK, S_FIN_ERR: nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
    if (doAdv) begin
      if (status.portLast) nxt = S_IDX;
      else begin
        stb.portInc = 1'b1;
        nxt = S_PORT_EVAL;
      end
    end
  end

  assign regReq   = (stb.busSel != BUS_NONE);
  assign cmdReady = (state == S_IDLE);
  assign rspDone  = (state == S_FIN_OK) || (state == S_FIN_ERR);
  assign rspErr   = (state == S_FIN_ERR);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone && cmdReady); // R1
  AST_BAD_CMD_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_CHECK && (status.opBad || status.vidZero)) |=> rspDone && rspErr); // R2
  AST_EMPTY_WRITE_OK: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_CHECK && status.opWrite && status.memEmpty && !status.vidZero)
      |=> rspDone && !rspErr); // R3
  AST_POLL_GIVEUP: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_POLL && xferOk && status.accBusy && status.pollLast) |=> rspErr); // R7
  AST_ERR_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    (regReq && regAck && regErr) |=> rspDone && rspErr && !regReq); // R9

endmodule

// File: rtl/vlan_tbl_seq.sv
module vlan_tbl_seq
  import vlan_seq_pkg::*;
#(
  parameter int NUM_PORTS = 9,
  parameter int VID_W = 12,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int POLL_LIMIT = 100,
  parameter logic [NUM_PORTS-1:0] VALID_MASK = 9'h11F,
  parameter int IDX_ADDR = 8'h10,
  parameter int ENTRY_ADDR = 8'h14,
  parameter int ACC_ADDR = 8'h1C,
  parameter int DEF_BASE = 8'h40
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdValid,
  input  logic [1:0]           cmdOp,
  input  logic [VID_W-1:0]     cmdVid,
  input  logic [NUM_PORTS-1:0] cmdMembers,
  input  logic [NUM_PORTS-1:0] cmdUntag,
  input  logic [NUM_PORTS-1:0] cmdDefault,
  output logic                 cmdReady,
  output logic                 rspDone,
  output logic                 rspErr,
  output logic [DATA_W-1:0]    rspEntry,
  output logic                 regReq,
  output logic                 regWrite,
  output logic [ADDR_W-1:0]    regAddr,
  output logic [DATA_W-1:0]    regWdata,
  input  logic                 regAck,
  input  logic                 regErr,
  input  logic [DATA_W-1:0]    regRdata
);

  seqStrobe_t stb;
  seqStatus_t status;

  vlan_seq_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .regAck(regAck),
    .regErr(regErr), .status(status), .stb(stb), .regReq(regReq),
    .cmdReady(cmdReady), .rspDone(rspDone), .rspErr(rspErr)
  );

  vlan_seq_dp #(
    .NUM_PORTS(NUM_PORTS), .VID_W(VID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .POLL_LIMIT(POLL_LIMIT), .VALID_MASK(VALID_MASK), .IDX_ADDR(IDX_ADDR),
    .ENTRY_ADDR(ENTRY_ADDR), .ACC_ADDR(ACC_ADDR), .DEF_BASE(DEF_BASE)
  ) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .cmdOp(cmdOp), .cmdVid(cmdVid),
    .cmdMembers(cmdMembers), .cmdUntag(cmdUntag), .cmdDefault(cmdDefault),
    .regRdata(regRdata), .status(status), .regWrite(regWrite),
    .regAddr(regAddr), .regWdata(regWdata), .rspEntry(rspEntry)
  );

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (regReq && !regAck) |=> regReq && $stable(regAddr) && $stable(regWdata)
                           && $stable(regWrite)); // R10

endmodule

// File: tb/vlan_tbl_seq_tb_top.sv
module vlan_tbl_seq_tb_top;

  localparam int IDX_A = 8'h10, ENT_A = 8'h14, ACC_A = 8'h1C, DEF_A = 8'h40;
  localparam logic [8:0] VALID = 9'h11F;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [1:0] cmdOp = '0;
  logic [11:0] cmdVid = '0;
  logic [8:0] cmdMembers = '0, cmdUntag = '0, cmdDefault = '0;
  logic cmdReady, rspDone, rspErr, regReq, regWrite;
  logic [31:0] rspEntry, regWdata;
  logic [7:0] regAddr;
  logic regAck = 1'b0, regErr = 1'b0;
  logic [31:0] regRdata = '0;

  always #2.5 clk = ~clk;

  vlan_tbl_seq dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdVid(cmdVid),
    .cmdMembers(cmdMembers), .cmdUntag(cmdUntag), .cmdDefault(cmdDefault),
    .cmdReady(cmdReady), .rspDone(rspDone), .rspErr(rspErr), .rspEntry(rspEntry),
    .regReq(regReq), .regWrite(regWrite), .regAddr(regAddr), .regWdata(regWdata),
    .regAck(regAck), .regErr(regErr), .regRdata(regRdata)
  );

  int total = 0, bad = 0, cycles = 0;
  string curTag = "R6";
  bit inCmd = 0;

  // register slave state (the model's view of the register space)
  logic [15:0] sDef [0:8];
  logic [11:0] sIdx = '0;
  logic [31:0] sEntry = '0;
  logic [31:0] tbl [int];
  int busyLeft = 0, busyCfg = 0, ackDelay = 0, errAt = -1, xferNo = 0, waitCnt = 0;
  logic [7:0] hA; logic [31:0] hD; logic hW;
  logic [41:0] expQ [$];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [41:0] mk(bit cmp, bit wr, int a, int d);
    return {cmp, wr, 8'(a), 32'(d)};
  endfunction

  task automatic serve();
    logic [41:0] e;
    int p;
    if (ackDelay > 0)
      chk(hA == regAddr && hD == regWdata && hW == regWrite, "R10",
          {hW, hA, hD}, {regWrite, regAddr, regWdata});
    if (expQ.size() == 0) begin
      chk(0, {curTag, " unexpected transfer"}, {regWrite, regAddr, regWdata}, 0);
    end else begin
      e = expQ.pop_front();
      chk(e[40] == regWrite && e[39:32] == regAddr && (!e[41] || e[31:0] == regWdata),
          curTag, {regWrite, regAddr, regWdata}, e[40:0]);
    end
    regRdata = '0;
    if (xferNo == errAt) begin
      regErr = 1'b1;
    end else begin
      regErr = 1'b0;
      p = (int'(regAddr) - DEF_A) / 2;
      if (regWrite) begin
        if (regAddr == IDX_A) sIdx = regWdata[11:0];
        else if (regAddr == ENT_A) sEntry = regWdata;
        else if (regAddr == ACC_A && regWdata[7]) begin
          if (regWdata[0]) sEntry = tbl.exists(int'(sIdx)) ? tbl[int'(sIdx)] : 32'h0;
          else tbl[int'(sIdx)] = sEntry;
          busyLeft = busyCfg;
        end else if (int'(regAddr) >= DEF_A && p < 9) sDef[p] = regWdata[15:0];
      end else begin
        if (regAddr == ACC_A) begin
          regRdata = {24'h0, busyLeft > 0, 7'h0};
          if (busyLeft > 0) busyLeft--;
        end else if (regAddr == ENT_A) regRdata = sEntry;
        else if (int'(regAddr) >= DEF_A && p < 9) regRdata = {16'h0, sDef[p]};
      end
    end
    xferNo++;
  endtask

  always @(negedge clk) begin
    if (!rstN || !regReq) begin
      regAck = 1'b0; regErr = 1'b0; waitCnt = 0;
    end else if (waitCnt >= ackDelay) begin
      serve();
      regAck = 1'b1; waitCnt = 0;
    end else begin
      if (waitCnt == 0) begin hA = regAddr; hD = regWdata; hW = regWrite; end
      regAck = 1'b0; regErr = 1'b0; waitCnt++;
    end
    if (rstN && rspDone && !inCmd) chk(0, "R1 spurious done", 1, 0);
  end

  logic [31:0] expEntry = '0;

  task automatic runCmd(input int op, input int vid, input int mem, input int unt,
                        input int dfl, input int busyN, input int dly, input int eAt,
                        input bit noise, input string tag);
    bit expErr = 0;
    logic [31:0] newEntry = expEntry;
    int polls, n;
    logic [8:0] upd = 9'(unt | dfl);
    curTag = tag; busyCfg = busyN; ackDelay = dly; errAt = eAt; xferNo = 0;
    expQ.delete();
    if (op == 3 || vid == 0) expErr = 1;
    else if (!(op == 1 && mem == 0)) begin
      for (int p = 0; p < 9; p++) begin
        if (op == 1 && upd[p]) expQ.push_back(mk(1, 1, DEF_A + 2 * p, vid));
        else if (op == 2 || (op == 1 && VALID[p])) begin
          expQ.push_back(mk(0, 0, DEF_A + 2 * p, 0));
          if (sDef[p] == 16'(vid)) expQ.push_back(mk(1, 1, DEF_A + 2 * p, 0));
        end
      end
      if (op == 0) expQ.delete();
      expQ.push_back(mk(1, 1, IDX_A, vid));
      if (op != 0) expQ.push_back(mk(1, 1, ENT_A, op == 1 ? ((unt << 9) | mem) : 0));
      expQ.push_back(mk(1, 1, ACC_A, op == 0 ? 32'h81 : 32'h80));
      polls = (busyN >= 100) ? 100 : busyN + 1;
      for (int i = 0; i < polls; i++) expQ.push_back(mk(0, 0, ACC_A, 0));
      if (busyN >= 100) expErr = 1;
      else if (op == 0) begin
        expQ.push_back(mk(0, 0, ENT_A, 0));
        newEntry = tbl.exists(vid) ? tbl[vid] : 32'h0;
      end
    end
    if (eAt >= 0 && eAt < expQ.size()) begin
      while (expQ.size() > eAt + 1) void'(expQ.pop_back());
      expErr = 1;
      newEntry = expEntry;
    end
    inCmd = 1;
    @(negedge clk);
    chk(cmdReady == 1'b1, "R1 ready before command", cmdReady, 1);
    cmdValid = 1; cmdOp = 2'(op); cmdVid = 12'(vid);
    cmdMembers = 9'(mem); cmdUntag = 9'(unt); cmdDefault = 9'(dfl);
    @(negedge clk);
    if (noise) begin
      cmdOp = 2'd2; cmdVid = 12'd5; cmdMembers = 9'h1FF;
      for (int i = 0; i < 4; i++) begin
        chk(cmdReady == 1'b0, "R1 busy not ready", cmdReady, 0);
        @(negedge clk);
      end
    end
    cmdValid = 0;
    n = 0;
    while (!rspDone && n < 3000) begin @(negedge clk); n++; end
    chk(rspDone == 1'b1, {tag, " done seen"}, rspDone, 1);
    chk(rspErr == expErr, {tag, " error result"}, rspErr, expErr);
    chk(rspEntry == newEntry, {tag, " R8 entry"}, rspEntry, newEntry);
    chk(expQ.size() == 0, {tag, " missing transfers"}, expQ.size(), 0);
    expEntry = newEntry;
    @(negedge clk);
    chk(rspDone == 1'b0, "R1 done one cycle", rspDone, 0);
    inCmd = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      chk(0, "watchdog", cycles, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < 9; p++) sDef[p] = '0;
    repeat (3) @(negedge clk);
    chk(cmdReady == 1 && regReq == 0 && rspDone == 0, "R1 reset state",
        {cmdReady, regReq, rspDone}, 3'b100);
    rstN = 1;
    @(negedge clk);
    // write: ports 0,1 set, valid 2,3,4,8 read, 5..7 skipped
    runCmd(1, 5, 'h113, 'h001, 'h002, 3, 0, -1, 0, "R4");
    chk(sDef[0] == 5 && sDef[1] == 5, "R4 defaults set", {sDef[0], sDef[1]}, {16'd5, 16'd5});
    runCmd(0, 5, 0, 0, 0, 2, 1, -1, 0, "R8");
    chk(rspEntry == 32'h313, "R6 entry packing", rspEntry, 32'h313);
    sDef[3] = 16'd7; sDef[5] = 16'd7;
    runCmd(1, 7, 'h00C, 0, 'h004, 0, 0, -1, 0, "R4");
    chk(sDef[3] == 0 && sDef[5] == 7 && sDef[2] == 7, "R4 clear and valid mask",
        {sDef[2], sDef[3], sDef[5]}, {16'd7, 16'd0, 16'd7});
    runCmd(2, 5, 0, 0, 0, 0, 2, -1, 0, "R5");
    chk(sDef[0] == 0 && sDef[1] == 0, "R5 defaults cleared", {sDef[0], sDef[1]}, 0);
    runCmd(0, 5, 0, 0, 0, 1, 0, -1, 0, "R6");
    chk(rspEntry == 0, "R6 delete left zero entry", rspEntry, 0);
    runCmd(1, 0, 'h1, 0, 0, 0, 0, -1, 0, "R2");
    runCmd(3, 9, 'h1, 0, 0, 0, 0, -1, 0, "R2");
    runCmd(1, 9, 0, 'h1, 'h1, 0, 0, -1, 0, "R3");
    runCmd(1, 9, 'h101, 'h100, 0, 99, 0, -1, 0, "R7");
    runCmd(1, 9, 'h101, 'h100, 0, 100, 0, -1, 0, "R7");
    runCmd(1, 10, 'h3, 0, 0, 0, 1, 2, 0, "R9");
    runCmd(0, 9, 0, 0, 0, 5, 0, 3, 0, "R9");
    runCmd(2, 7, 0, 0, 0, 2, 1, -1, 1, "R1");
    runCmd(0, 9, 0, 0, 0, 0, 2, -1, 0, "R8");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule